// File: doc/BRIEF.md
# Tree-Scheduled Inclusive Prefix Adder

This block produces the inclusive prefix sums of `N = 2^K` operand words. The operands are held in the bottom row of a complete binary tree of node registers, and a controller walks the tree one level per clock cycle. The walk has four phases. First it forms subtree sums from the bottom up. Next it folds each pair of leaves together. Then each internal right node takes its left neighbour's total and each internal left node is cleared to zero. Last, it pushes values down from the top and adds them into the children below. When the walk ends, leaf `i` holds the wrapping sum of operands `0..i`, and all `N` results appear at once on a flat output bus.

A host drives the operands on `operand_i`, pulses `start_i` for one cycle while the block is idle or finished, and waits for `done_o`. The results stay valid, and `done_o` stays high, until the next accepted start. The controller has six states. `IDLE` and `DONE` go to `UP` on a start, and that start also loads the leaves. `UP` stays in `UP`, moving up one level each cycle, until it reaches level one. From there it goes to `LEAF`. `LEAF` goes to `SWAP`, and `SWAP` goes to `DOWN`. `DOWN` stays in `DOWN`, moving down one level each cycle, and goes to `DONE` after it has updated the leaves.

Top module: `pscan_top`

## Requirements
- R1: After reset, `done_o` is 0 and every word of `prefix_o` is 0.
- R2: A start pulse in the idle or finished state captures `operand_i` into the leaves. `done_o` is 0 after the next clock edge.
- R3: When `done_o` is 1, word `i` of `prefix_o` (bits `i*W +: W`) equals the sum of operand words `0..i`. Operand word `j` sits at bits `j*W +: W` of `operand_i`. An all-zero input gives all-zero results, because zero is the identity element.
- R4: `done_o` rises exactly after the `2K+1`-th clock edge counted from the edge that sampled the start: `K-1` upward steps, one leaf-pair step, one swap step, `K-1` downward steps, and the loading edge.
- R5: A start pulse while a scan is in progress is ignored. The result and the latency of the running scan do not change, and the new operand value is not captured.
- R6: While `done_o` is 1 and no start arrives, `done_o` stays 1 and `prefix_o` stays unchanged, even if `operand_i` changes.
- R7: All sums wrap modulo `2^W`.
- R8: The upward phase visits levels `K-1` down to 1, one per cycle. The downward phase visits levels 1 up to `K-1`, one per cycle.
- R9: A start in the finished state starts a new scan on the new operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to load operands and scan |
| operand_i | input | N*W | Operand words, word j at bits j*W +: W |
| done_o | output | 1 | High while results are valid |
| prefix_o | output | N*W | Inclusive prefix sums, word i at bits i*W +: W |

## Verification
The case that is hardest to reach from the ports is a start pulse that lands in the middle of the level walk. By then the leaves have been partly overwritten, so if the pulse is accepted, the scan either reloads or its schedule restarts, and the result or the latency changes. The bench injects a second start, carrying different operands, on a chosen edge inside the walk. It then requires the first scan's prefix values and unchanged timing. A separate finished-state restart confirms that the same pulse is accepted once the walk has ended.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP,
        ST_LEAF,
        ST_SWAP,
        ST_DOWN,
        ST_DONE
    } pscan_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_UP,
        OP_LEAF,
        OP_SWAP,
        OP_DOWN
    } pscan_op_e;

    // Tree level of a heap-indexed node (root = 1 at level 0).
    function automatic int level_of(input int idx);
        int lv;
        int v;
        lv = 0;
        v  = idx;
        while (v > 1) begin
            v  = v / 2;
            lv = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/pscan_ctrl.sv
module pscan_ctrl
    import pscan_pkg::*;
#(
    parameter int K  = 3,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output pscan_op_e     op_o,
    output logic [LW-1:0] lvl_o,
    output logic          done_o
);

    localparam logic [LW-1:0] TOP_LVL = LW'(K - 1);
    localparam logic [LW-1:0] ONE_LVL = LW'(1);

    pscan_state_e  state_q, state_d;
    logic [LW-1:0] lvl_q, lvl_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = ST_UP;
                    lvl_d   = TOP_LVL;
                end
            end
            ST_UP: begin
                if (lvl_q == ONE_LVL) state_d = ST_LEAF;
                else                  lvl_d   = lvl_q - ONE_LVL;
            end
            ST_LEAF: state_d = ST_SWAP;
            ST_SWAP: begin
                state_d = ST_DOWN;
                lvl_d   = ONE_LVL;
            end
            ST_DOWN: begin
                if (lvl_q == TOP_LVL) state_d = ST_DONE;
                else                  lvl_d   = lvl_q + ONE_LVL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        op_o   = OP_HOLD;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: op_o = start_i ? OP_LOAD : OP_HOLD;
            ST_DONE: begin
                op_o   = start_i ? OP_LOAD : OP_HOLD;
                done_o = 1'b1;
            end
            ST_UP:   op_o = OP_UP;
            ST_LEAF: op_o = OP_LEAF;
            ST_SWAP: op_o = OP_SWAP;
            ST_DOWN: op_o = OP_DOWN;
            default: op_o = OP_HOLD;
        endcase
    end
    assign lvl_o = lvl_q;

    // R8: upward walk descends one level per cycle
    p_up_descend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && lvl_q != ONE_LVL) |=>
            (state_q == ST_UP && lvl_q == $past(lvl_q) - ONE_LVL));

    // R8: downward walk ascends one level per cycle
    p_down_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && lvl_q != TOP_LVL) |=>
            (state_q == ST_DOWN && lvl_q == $past(lvl_q) + ONE_LVL));

    // R5: a busy scan never restarts at the top level
    p_busy_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_DONE) |=>
            !(state_q == ST_UP && lvl_q == TOP_LVL && $past(state_q) != ST_IDLE
              && $past(state_q) != ST_DONE));

    // R4: the swap step always follows the leaf step
    p_leaf_then_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAF) |=> (state_q == ST_SWAP));

endmodule

// File: rtl/pscan_tree.sv
module pscan_tree
    import pscan_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int LW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  pscan_op_e      op_i,
    input  logic [LW-1:0]  lvl_i,
    input  logic [N*W-1:0] operand_i,
    output logic [N*W-1:0] prefix_o
);

    localparam int NODES = 2 * N;

    // node 1 (root) is never used; nodes 2..2N-1 hold levels 1..K
    logic [W-1:0] node_w [2:NODES-1];

    for (genvar j = 2; j < NODES; j++) begin : g_node
        localparam int  L   = level_of(j);
        localparam bit  ODD = (j % 2) == 1;
        localparam int  SIB = ODD ? j - 1 : j;
        localparam int  PAR = (L >= 2) ? j / 2 : j;
        localparam bit  HAS_PAR = (L >= 2);

        logic [W-1:0] r_q;

        if (j >= N) begin : g_leaf
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q <= '0;
                end else begin
                    case (op_i)
                        OP_LOAD: r_q <= operand_i[(j-N)*W +: W];
                        OP_LEAF: if (ODD) r_q <= node_w[SIB] + r_q;
                        OP_DOWN: if (lvl_i == LW'(L - 1)) r_q <= r_q + node_w[PAR];
                        default: r_q <= r_q;
                    endcase
                end
            end
        end else begin : g_inner
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q <= '0;
                end else begin
                    case (op_i)
                        OP_UP:   if (lvl_i == LW'(L)) r_q <= node_w[2*j] + node_w[2*j+1];
                        OP_SWAP: r_q <= ODD ? node_w[SIB] : '0;
                        OP_DOWN: if (HAS_PAR && lvl_i == LW'(L - 1)) r_q <= r_q + node_w[PAR];
                        default: r_q <= r_q;
                    endcase
                end
            end
        end

        assign node_w[j] = r_q;
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign prefix_o[i*W +: W] = node_w[N+i];
    end

    // R3: after the swap step the leftmost level-one node holds the identity
    p_swap_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SWAP) |=> (node_w[2] == '0));

    // R3: leaf 0 never changes between load and the next load
    p_first_leaf_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_LOAD) |=> $stable(node_w[N]));

endmodule

// File: rtl/pscan_top.sv
module pscan_top
    import pscan_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N*W-1:0] operand_i,
    output logic           done_o,
    output logic [N*W-1:0] prefix_o
);

    localparam int K  = $clog2(N);
    localparam int LW = $clog2(K + 1);

    pscan_op_e     op_w;
    logic [LW-1:0] lvl_w;

    pscan_ctrl #(.K(K), .LW(LW)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .op_o   (op_w),
        .lvl_o  (lvl_w),
        .done_o (done_o)
    );

    pscan_tree #(.N(N), .W(W), .LW(LW)) tree_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_w),
        .lvl_i    (lvl_w),
        .operand_i(operand_i),
        .prefix_o (prefix_o)
    );

    // R6: results and done persist until a start
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(prefix_o)));

    // R2: an accepted start drops done on the next edge
    p_start_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !done_o);

endmodule

// File: tb/pscan_top_tb_top.sv
module pscan_top_tb_top;

    localparam int N = 8;
    localparam int W = 16;
    localparam int K = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [N*W-1:0] operand_i = '0;
    logic           done_o;
    logic [N*W-1:0] prefix_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [W-1:0] ops [N];

    always #5 clk = ~clk;

    pscan_top #(.N(N), .W(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .operand_i(operand_i),
        .done_o   (done_o),
        .prefix_o (prefix_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N*W-1:0] pack_ops();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = ops[i];
        return v;
    endfunction

    // Compare all outputs against a software running sum of ops.
    task automatic check_prefix(input string req);
        logic [W-1:0] run;
        run = '0;
        for (int i = 0; i < N; i++) begin
            run = run + ops[i];
            chk(prefix_o[i*W +: W] == run, req, prefix_o[i*W +: W], run);
        end
    endtask

    // Pulse start with ops; track latency; optionally inject a busy start
    // carrying other operands before edge number inj (0 = none).
    task automatic scan_and_wait(input int inj, input string req);
        bit early;
        early = 1'b0;
        operand_i = pack_ops();
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R2 done low after start", done_o, 0);
        for (int e = 1; e <= 2 * K; e++) begin
            if (done_o) early = 1'b1;
            if (e == inj) begin
                operand_i = ~pack_ops();
                start_i   = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        chk(!early, {req, " R4 done early"}, early, 0);
        chk(done_o == 1'b1, {req, " R4 done at 2K+1 edges"}, done_o, 1);
    endtask

    task automatic t_reset();
        chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
        chk(prefix_o == '0, "R1 outputs after reset", prefix_o[W-1:0], 0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < N; i++) ops[i] = W'(i + 1);
        scan_and_wait(0, "R3 ramp");
        check_prefix("R3 ramp");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < N; i++) ops[i] = W'(16'hF000 + i * 16'h0333);
        scan_and_wait(0, "R7 wrap");
        check_prefix("R7 wrap");
    endtask

    task automatic t_mixed();
        logic [31:0] s;
        s = 32'h1234_5678;
        for (int i = 0; i < N; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            ops[i] = s[W+7:8];
        end
        scan_and_wait(0, "R3 mixed");
        check_prefix("R3 mixed");
    endtask

    task automatic t_zero();
        for (int i = 0; i < N; i++) ops[i] = '0;
        scan_and_wait(0, "R3 zero");
        check_prefix("R3 zero identity");
    endtask

    task automatic t_busy();
        for (int i = 0; i < N; i++) ops[i] = W'(3 * i + 7);
        scan_and_wait(2, "R5 busy start");
        check_prefix("R5 busy start ignored");
        for (int i = 0; i < N; i++) ops[i] = W'(100 - i);
        scan_and_wait(2 * K - 1, "R5 late busy start");
        check_prefix("R5 late busy start ignored");
    endtask

    task automatic t_hold();
        logic [N*W-1:0] snap;
        snap = prefix_o;
        operand_i = ~operand_i;
        repeat (6) @(negedge clk);
        chk(done_o == 1'b1, "R6 done held", done_o, 1);
        chk(prefix_o == snap, "R6 outputs held", prefix_o[W-1:0], snap[W-1:0]);
    endtask

    task automatic t_restart();
        for (int i = 0; i < N; i++) ops[i] = W'(i * i + 2);
        chk(done_o == 1'b1, "R9 in finished state", done_o, 1);
        scan_and_wait(0, "R9 restart");
        check_prefix("R9 restart result");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ramp();
        t_hold();
        t_wrap();
        t_mixed();
        t_zero();
        t_busy();
        t_restart();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule